// File: doc/BRIEF.md
# Address Stack Program Sequencer

This block is the program-counter and return-address unit of a small 4-bit microcontroller core. Each cycle it presents the address of the next instruction to fetch. It takes in the instruction word that belongs to that address and works out the following address. The instructions it acts on are direct branches, direct calls, jumps and calls through a 16-bit address register, returns, and pushes and pops of the address register. Return addresses and saved address-register values share one stack. The stack grows downward and is indexed by a stack pointer.

The arithmetic unit can ask for the following instruction to be skipped. In that case the sequencer annuls the next executed instruction: the address advances and nothing else changes. One return variant sets up the same annulment at the return site. An interrupt-entry request pushes the address of the instruction that was about to run and jumps to a fixed vector. It also saves a small status word together with any pending skip. The interrupt return restores both. When the stack is pushed while full, the block flags overflow and drops the push. When it is popped while empty, the block flags underflow.

Top module: `addr_seq`

## Requirements
- R1: After reset the fetch address is 0, the stack pointer equals DEPTH (empty), the address register is 0, and annul, overflow, underflow and restore outputs are low.
- R2: An executed instruction that is not a control instruction advances the fetch address by one. From PROG_TOP the address wraps to 0; the default PROG_TOP is 3FFFh, and a 2FFFh setting gives the smaller memory.
- R3: A direct branch has opcode bits [15:11] of 01100 or 01101. The fetch address becomes {instr[11], instr[10:0]}, zero-extended, so bit 11 of the opcode selects page 0 or page 1.
- R4: A direct call (bits [15:11] = 11100) decrements the stack pointer and pushes the fetch address plus one. The new fetch address is instr[10:0], with bit 11 and above cleared.
- R5: The register jump (bits [15:4] = 0011_1000_0100) loads the fetch address from the low 14 bits of the address register. The register call (0011_1000_0101) does the same after pushing the fetch address plus one.
- R6: The return (bits [15:4] = 0011_1000_1110) pops the fetch address and increments the stack pointer. The skipping return (0011_1001_1110) does the same and also annuls the next executed instruction.
- R7: skip_i asserted with an executed, non-annulled instruction annuls the next executed instruction. annul_o is high while an annulment is pending. An annulled instruction only advances the fetch address by one; it changes neither the stack nor the address register, and it ignores skip_i.
- R8: The push-register instruction (bits [15:4] = 0011_1000_1101) decrements the stack pointer and stores the address register. The pop-register instruction (0011_1000_1100) loads the address register from the stack and increments the pointer. The increment instruction (0011_1000_1001) adds one to the address register, wrapping at 16 bits.
- R9: A push with the stack pointer at 0 raises ovf_o for one cycle. The pointer and the stored entries stay unchanged, and the control transfer of the instruction still takes place.
- R10: A pop with the stack pointer at DEPTH raises unf_o for one cycle. The pointer stays unchanged and the popped value reads as 0.
- R11: irq_i takes priority over exec_i. It pushes the current fetch address without incrementing it and loads IRQ_VEC. It saves status_i together with the pending-skip state, and it clears the pending skip.
- R12: The interrupt return (bits [15:4] = 0011_1010_1110) pops the fetch address and increments the stack pointer. It pulses rest_vld_o for one cycle with the saved status on rest_stat_o, and it restores the saved pending skip.
- R13: With exec_i and irq_i both low, no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exec_i | input | 1 | instr_i is the instruction at fetch_addr_o and executes this cycle |
| instr_i | input | 16 | Instruction word |
| skip_i | input | 1 | Skip request from the arithmetic unit for the current instruction |
| irq_i | input | 1 | Interrupt-entry request |
| status_i | input | STW | Status word saved on interrupt entry |
| fetch_addr_o | output | PCW | Address of the next instruction to execute |
| ar_o | output | ARW | Address register |
| sp_o | output | SPW | Stack pointer (DEPTH = empty, 0 = full) |
| annul_o | output | 1 | The next executed instruction will be annulled |
| ovf_o | output | 1 | One-cycle pulse: a push hit a full stack |
| unf_o | output | 1 | One-cycle pulse: a pop hit an empty stack |
| rest_vld_o | output | 1 | One-cycle pulse: interrupt status restored |
| rest_stat_o | output | STW | Saved interrupt status |

## Verification
The assertions check the following on every cycle:
- the stack pointer never leaves its range;
- an overflow or underflow pulse appears only when the pointer sat at the matching limit and stays there;
- an annulled instruction leaves the stack and the address register alone;
- interrupt entry always lands on the vector;
- a direct branch always lands on the page its opcode names;
- an idle cycle changes nothing.

Some behaviour depends on what was stored earlier, and only the bench's scenarios can show it. This covers return addresses coming back in the right order through nested calls, and a dropped push leaving older return addresses intact. It also covers a skip that is pending at interrupt entry reappearing after the interrupt return, and the wrap of the fetch address at the top of program space.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_BR,
        OP_CALL,
        OP_JMP_AR,
        OP_CALL_AR,
        OP_INC_AR,
        OP_PUSH_AR,
        OP_POP_AR,
        OP_RET,
        OP_RET_SKIP,
        OP_RET_INT
    } seq_op_e;

    localparam logic [4:0] MAJ_BR0   = 5'b01100;
    localparam logic [4:0] MAJ_BR1   = 5'b01101;
    localparam logic [4:0] MAJ_CALL  = 5'b11100;
    localparam logic [4:0] MAJ_MISC  = 5'b00111;

    localparam logic [6:0] SUB_JMP_AR  = 7'b000_0100;
    localparam logic [6:0] SUB_CALL_AR = 7'b000_0101;
    localparam logic [6:0] SUB_INC_AR  = 7'b000_1001;
    localparam logic [6:0] SUB_PUSH_AR = 7'b000_1101;
    localparam logic [6:0] SUB_POP_AR  = 7'b000_1100;
    localparam logic [6:0] SUB_RET     = 7'b000_1110;
    localparam logic [6:0] SUB_RET_SK  = 7'b001_1110;
    localparam logic [6:0] SUB_RET_INT = 7'b010_1110;

endpackage

// File: rtl/seq_decode.sv
module seq_decode
    import seq_pkg::*;
#(
    parameter int PCW = 14
) (
    input  logic [15:0]    instr_i,
    output seq_op_e        op_o,
    output logic [PCW-1:0] tgt_o
);

    logic [4:0] major;
    logic [6:0] minor;

    assign major = instr_i[15:11];
    assign minor = instr_i[10:4];

    always_comb begin
        op_o  = OP_NONE;
        tgt_o = '0;
        unique case (major)
            MAJ_BR0, MAJ_BR1: begin
                op_o  = OP_BR;
                tgt_o = PCW'({instr_i[11], instr_i[10:0]});
            end
            MAJ_CALL: begin
                op_o  = OP_CALL;
                tgt_o = PCW'({1'b0, instr_i[10:0]});
            end
            MAJ_MISC: begin
                case (minor)
                    SUB_JMP_AR:  op_o = OP_JMP_AR;
                    SUB_CALL_AR: op_o = OP_CALL_AR;
                    SUB_INC_AR:  op_o = OP_INC_AR;
                    SUB_PUSH_AR: op_o = OP_PUSH_AR;
                    SUB_POP_AR:  op_o = OP_POP_AR;
                    SUB_RET:     op_o = OP_RET;
                    SUB_RET_SK:  op_o = OP_RET_SKIP;
                    SUB_RET_INT: op_o = OP_RET_INT;
                    default:     op_o = OP_NONE;
                endcase
            end
            default: op_o = OP_NONE;
        endcase
    end

endmodule

// File: rtl/seq_stack.sv
module seq_stack #(
    parameter  int DEPTH = 8,
    parameter  int W     = 16,
    localparam int SPW   = $clog2(DEPTH + 1),
    localparam int IDXW  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push_i,
    input  logic           pop_i,
    input  logic [W-1:0]   wdata_i,
    output logic [W-1:0]   rdata_o,
    output logic [SPW-1:0] sp_o,
    output logic           ovf_o,
    output logic           unf_o
);

    localparam logic [SPW-1:0] SP_EMPTY = SPW'(DEPTH);

    typedef struct packed {
        logic [SPW-1:0] sp;
        logic           ovf;
        logic           unf;
    } stk_t;

    stk_t            stk_d, stk_q;
    logic [W-1:0]    mem_q [DEPTH];
    logic            wr_en;
    logic [IDXW-1:0] wr_idx;

    always_comb begin
        stk_d     = stk_q;
        stk_d.ovf = 1'b0;
        stk_d.unf = 1'b0;
        wr_en     = 1'b0;
        wr_idx    = IDXW'(stk_q.sp - 1'b1);
        if (push_i) begin
            if (stk_q.sp == '0) begin
                stk_d.ovf = 1'b1;
            end else begin
                stk_d.sp = stk_q.sp - 1'b1;
                wr_en    = 1'b1;
            end
        end else if (pop_i) begin
            if (stk_q.sp == SP_EMPTY) begin
                stk_d.unf = 1'b1;
            end else begin
                stk_d.sp = stk_q.sp + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stk_q <= '{sp: SP_EMPTY, ovf: 1'b0, unf: 1'b0};
        end else begin
            stk_q <= stk_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_idx] <= wdata_i;
        end
    end

    assign rdata_o = (stk_q.sp == SP_EMPTY) ? '0 : mem_q[IDXW'(stk_q.sp)];
    assign sp_o    = stk_q.sp;
    assign ovf_o   = stk_q.ovf;
    assign unf_o   = stk_q.unf;

endmodule

// File: rtl/addr_seq.sv
module addr_seq
    import seq_pkg::*;
#(
    parameter  int             PCW      = 14,
    parameter  int             ARW      = 16,
    parameter  int             DEPTH    = 8,
    parameter  int             STW      = 4,
    parameter  logic [PCW-1:0] PROG_TOP = 14'h3FFF,
    parameter  logic [PCW-1:0] IRQ_VEC  = 14'h0010,
    localparam int             SPW      = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           exec_i,
    input  logic [15:0]    instr_i,
    input  logic           skip_i,
    input  logic           irq_i,
    input  logic [STW-1:0] status_i,
    output logic [PCW-1:0] fetch_addr_o,
    output logic [ARW-1:0] ar_o,
    output logic [SPW-1:0] sp_o,
    output logic           annul_o,
    output logic           ovf_o,
    output logic           unf_o,
    output logic           rest_vld_o,
    output logic [STW-1:0] rest_stat_o
);

    typedef struct packed {
        logic [PCW-1:0] pc;
        logic [ARW-1:0] ar;
        logic           skip;
        logic [STW:0]   isave;
        logic           rest;
    } seq_t;

    seq_t           seq_d, seq_q;
    seq_op_e        op;
    logic [PCW-1:0] tgt;
    logic [PCW-1:0] pc_inc;
    logic           push, pop;
    logic [ARW-1:0] wdata, rdata;

    seq_decode #(.PCW(PCW)) u_dec (
        .instr_i (instr_i),
        .op_o    (op),
        .tgt_o   (tgt)
    );

    seq_stack #(.DEPTH(DEPTH), .W(ARW)) u_stk (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .pop_i   (pop),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .sp_o    (sp_o),
        .ovf_o   (ovf_o),
        .unf_o   (unf_o)
    );

    assign pc_inc = (seq_q.pc == PROG_TOP) ? '0 : seq_q.pc + 1'b1;

    always_comb begin
        seq_d      = seq_q;
        seq_d.rest = 1'b0;
        push       = 1'b0;
        pop        = 1'b0;
        wdata      = ARW'(pc_inc);
        if (irq_i) begin
            push        = 1'b1;
            wdata       = ARW'(seq_q.pc);
            seq_d.pc    = IRQ_VEC;
            seq_d.isave = {seq_q.skip, status_i};
            seq_d.skip  = 1'b0;
        end else if (exec_i) begin
            seq_d.pc   = pc_inc;
            seq_d.skip = 1'b0;
            if (!seq_q.skip) begin
                seq_d.skip = skip_i;
                case (op)
                    OP_BR:      seq_d.pc = tgt;
                    OP_CALL: begin
                        push     = 1'b1;
                        seq_d.pc = tgt;
                    end
                    OP_JMP_AR:  seq_d.pc = seq_q.ar[PCW-1:0];
                    OP_CALL_AR: begin
                        push     = 1'b1;
                        seq_d.pc = seq_q.ar[PCW-1:0];
                    end
                    OP_INC_AR:  seq_d.ar = seq_q.ar + 1'b1;
                    OP_PUSH_AR: begin
                        push  = 1'b1;
                        wdata = seq_q.ar;
                    end
                    OP_POP_AR: begin
                        pop      = 1'b1;
                        seq_d.ar = rdata;
                    end
                    OP_RET: begin
                        pop      = 1'b1;
                        seq_d.pc = rdata[PCW-1:0];
                    end
                    OP_RET_SKIP: begin
                        pop        = 1'b1;
                        seq_d.pc   = rdata[PCW-1:0];
                        seq_d.skip = 1'b1;
                    end
                    OP_RET_INT: begin
                        pop        = 1'b1;
                        seq_d.pc   = rdata[PCW-1:0];
                        seq_d.skip = seq_q.isave[STW];
                        seq_d.rest = 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign fetch_addr_o = seq_q.pc;
    assign ar_o         = seq_q.ar;
    assign annul_o      = seq_q.skip;
    assign rest_vld_o   = seq_q.rest;
    assign rest_stat_o  = seq_q.isave[STW-1:0];

endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
    parameter int             PCW     = 14,
    parameter int             ARW     = 16,
    parameter int             DEPTH   = 8,
    parameter logic [PCW-1:0] IRQ_VEC = 14'h0010,
    parameter int             SPW     = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           exec_i,
    input logic [15:0]    instr_i,
    input logic           irq_i,
    input logic [PCW-1:0] fetch_addr_o,
    input logic [ARW-1:0] ar_o,
    input logic [SPW-1:0] sp_o,
    input logic           annul_o,
    input logic           ovf_o,
    input logic           unf_o
);

    localparam logic [SPW-1:0] SP_EMPTY = SPW'(DEPTH);

    assert_sp_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sp_o <= SP_EMPTY);

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> ($past(sp_o) == '0 && sp_o == '0));

    assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        unf_o |-> ($past(sp_o) == SP_EMPTY && sp_o == SP_EMPTY));

    assert_annul_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && !irq_i && annul_o) |=>
            (ar_o == $past(ar_o) && sp_o == $past(sp_o) && !annul_o));

    assert_irq_vector_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_i |=> (fetch_addr_o == IRQ_VEC && !annul_o));

    assert_branch_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && !irq_i && !annul_o && instr_i[15:12] == 4'b0110) |=>
            fetch_addr_o == PCW'($past(instr_i[11:0])));

    assert_idle_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!exec_i && !irq_i) |=>
            ($stable(fetch_addr_o) && $stable(ar_o) && $stable(sp_o)));

endmodule

bind addr_seq seq_checker #(
    .PCW(PCW), .ARW(ARW), .DEPTH(DEPTH), .IRQ_VEC(IRQ_VEC), .SPW(SPW)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .exec_i       (exec_i),
    .instr_i      (instr_i),
    .irq_i        (irq_i),
    .fetch_addr_o (fetch_addr_o),
    .ar_o         (ar_o),
    .sp_o         (sp_o),
    .annul_o      (annul_o),
    .ovf_o        (ovf_o),
    .unf_o        (unf_o)
);

// File: tb/sim_addr_seq.sv
`timescale 1ns/1ps
module sim_addr_seq;

    localparam int PCW = 14;
    localparam int ARW = 16;
    localparam int DEPTH = 8;
    localparam int STW = 4;
    localparam int SPW = $clog2(DEPTH + 1);
    localparam logic [PCW-1:0] VEC = 14'h0010;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           exec_i = 1'b0;
    logic [15:0]    instr_i = '0;
    logic           skip_i = 1'b0;
    logic           irq_i = 1'b0;
    logic [STW-1:0] status_i = '0;
    logic [PCW-1:0] fetch_addr_o;
    logic [ARW-1:0] ar_o;
    logic [SPW-1:0] sp_o;
    logic           annul_o, ovf_o, unf_o, rest_vld_o;
    logic [STW-1:0] rest_stat_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    addr_seq u0 (
        .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .instr_i(instr_i),
        .skip_i(skip_i), .irq_i(irq_i), .status_i(status_i),
        .fetch_addr_o(fetch_addr_o), .ar_o(ar_o), .sp_o(sp_o),
        .annul_o(annul_o), .ovf_o(ovf_o), .unf_o(unf_o),
        .rest_vld_o(rest_vld_o), .rest_stat_o(rest_stat_o)
    );

    typedef struct packed {
        logic [15:0]    ins;
        logic           sk;
        logic [PCW-1:0] pc;
        logic [SPW-1:0] sp;
        logic [ARW-1:0] ar;
        logic           an;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{16'h0000, 1'b0, 14'h0001, 4'd8, 16'h0000, 1'b0}, // R2 plain
        '{16'h3890, 1'b0, 14'h0002, 4'd8, 16'h0001, 1'b0}, // R8 inc
        '{16'h3890, 1'b0, 14'h0003, 4'd8, 16'h0002, 1'b0}, // R8 inc
        '{16'h6923, 1'b0, 14'h0923, 4'd8, 16'h0002, 1'b0}, // R3 page1
        '{16'hE045, 1'b0, 14'h0045, 4'd7, 16'h0002, 1'b0}, // R4 call
        '{16'h38D0, 1'b0, 14'h0046, 4'd6, 16'h0002, 1'b0}, // R8 push
        '{16'h3890, 1'b0, 14'h0047, 4'd6, 16'h0003, 1'b0}, // R8 inc
        '{16'h38C0, 1'b0, 14'h0048, 4'd7, 16'h0002, 1'b0}, // R8 pop
        '{16'h38E0, 1'b0, 14'h0924, 4'd8, 16'h0002, 1'b0}, // R6 ret
        '{16'h62BC, 1'b0, 14'h02BC, 4'd8, 16'h0002, 1'b0}, // R3 page0
        '{16'h3850, 1'b0, 14'h0002, 4'd7, 16'h0002, 1'b0}, // R5 call ar
        '{16'h39E0, 1'b0, 14'h02BD, 4'd8, 16'h0002, 1'b1}, // R6 ret skip
        '{16'h3890, 1'b0, 14'h02BE, 4'd8, 16'h0002, 1'b0}, // R7 annulled inc
        '{16'h3840, 1'b0, 14'h0002, 4'd8, 16'h0002, 1'b0}, // R5 jump ar
        '{16'h0000, 1'b1, 14'h0003, 4'd8, 16'h0002, 1'b1}, // R7 skip req
        '{16'h6800, 1'b0, 14'h0004, 4'd8, 16'h0002, 1'b0}, // R7 annulled br
        '{16'h6800, 1'b0, 14'h0800, 4'd8, 16'h0002, 1'b0}  // R3 br
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input logic ex, input logic [15:0] ins, input logic sk,
                        input logic irq, input logic [STW-1:0] st);
        @(negedge clk);
        exec_i = ex; instr_i = ins; skip_i = sk; irq_i = irq; status_i = st;
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; exec_i = 0; instr_i = '0; skip_i = 0; irq_i = 0; status_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 pc", 32'(fetch_addr_o), 0);
        chk("R1 sp", 32'(sp_o), DEPTH);
        chk("R1 ar", 32'(ar_o), 0);
        chk("R1 flags", {28'h0, annul_o, ovf_o, unf_o, rest_vld_o}, 0);

        // vector walk
        for (int i = 0; i < NV; i++) begin
            step(1'b1, VECS[i].ins, VECS[i].sk, 1'b0, '0);
            chk($sformatf("R2-table vec%0d pc", i), 32'(fetch_addr_o), 32'(VECS[i].pc));
            chk($sformatf("R8-table vec%0d sp", i), 32'(sp_o), 32'(VECS[i].sp));
            chk($sformatf("R8-table vec%0d ar", i), 32'(ar_o), 32'(VECS[i].ar));
            chk($sformatf("R7-table vec%0d annul", i), 32'(annul_o), 32'(VECS[i].an));
        end

        // R13 idle cycles hold everything
        step(1'b0, 16'h3890, 1'b1, 1'b0, '0);
        step(1'b0, 16'h3890, 1'b0, 1'b0, '0);
        chk("R13 pc", 32'(fetch_addr_o), 32'h800);
        chk("R13 ar", 32'(ar_o), 32'h2);
        chk("R13 annul", 32'(annul_o), 0);

        // R9 overflow: eight calls fill the stack, ninth is dropped
        do_reset();
        for (int k = 0; k < DEPTH; k++) begin
            step(1'b1, 16'hE000 | 16'((k + 1) * 16), 1'b0, 1'b0, '0);
        end
        chk("R4 sp full", 32'(sp_o), 0);
        chk("R9 no ovf yet", 32'(ovf_o), 0);
        step(1'b1, 16'hE100, 1'b0, 1'b0, '0);
        chk("R9 ovf pulse", 32'(ovf_o), 1);
        chk("R9 sp held", 32'(sp_o), 0);
        chk("R9 pc still moved", 32'(fetch_addr_o), 32'h100);
        step(1'b1, 16'h38E0, 1'b0, 1'b0, '0);
        chk("R9 ovf cleared", 32'(ovf_o), 0);
        chk("R9 top entry kept", 32'(fetch_addr_o), 32'h71);
        chk("R6 sp after ret", 32'(sp_o), 1);
        step(1'b1, 16'h38E0, 1'b0, 1'b0, '0);
        chk("R6 nested ret", 32'(fetch_addr_o), 32'h61);

        // R10 underflow
        do_reset();
        step(1'b1, 16'h6555, 1'b0, 1'b0, '0);
        step(1'b1, 16'h38E0, 1'b0, 1'b0, '0);
        chk("R10 unf pulse", 32'(unf_o), 1);
        chk("R10 sp held", 32'(sp_o), DEPTH);
        chk("R10 pc zero", 32'(fetch_addr_o), 0);
        step(1'b1, 16'h38C0, 1'b0, 1'b0, '0);
        chk("R10 ar zero", 32'(ar_o), 0);
        step(1'b1, 16'h0000, 1'b0, 1'b0, '0);
        chk("R10 unf cleared", 32'(unf_o), 0);

        // R11 / R12 interrupt entry with a pending skip
        do_reset();
        step(1'b1, 16'h6300, 1'b0, 1'b0, '0);
        step(1'b1, 16'h0000, 1'b1, 1'b0, '0);
        chk("R7 pending", 32'(annul_o), 1);
        step(1'b1, 16'h3890, 1'b0, 1'b1, 4'hA);
        chk("R11 vector", 32'(fetch_addr_o), 32'(VEC));
        chk("R11 sp", 32'(sp_o), 7);
        chk("R11 skip cleared", 32'(annul_o), 0);
        chk("R11 exec ignored", 32'(ar_o), 0);
        step(1'b1, 16'h3890, 1'b0, 1'b0, '0);
        chk("R11 isr first runs", 32'(ar_o), 1);
        step(1'b1, 16'h3AE0, 1'b0, 1'b0, '0);
        chk("R12 pc", 32'(fetch_addr_o), 32'h301);
        chk("R12 sp", 32'(sp_o), 8);
        chk("R12 rest pulse", 32'(rest_vld_o), 1);
        chk("R12 rest status", 32'(rest_stat_o), 32'hA);
        chk("R12 skip restored", 32'(annul_o), 1);
        step(1'b1, 16'h3890, 1'b0, 1'b0, '0);
        chk("R12 rest pulse ends", 32'(rest_vld_o), 0);
        chk("R12 annulled after return", 32'(ar_o), 1);
        chk("R12 pc", 32'(fetch_addr_o), 32'h302);

        // R2 wrap at top of program space
        do_reset();
        for (int k = 0; k < 16383; k++) begin
            step(1'b1, 16'h0000, 1'b0, 1'b0, '0);
        end
        chk("R2 top", 32'(fetch_addr_o), 32'h3FFF);
        step(1'b1, 16'h0000, 1'b0, 1'b0, '0);
        chk("R2 wrap", 32'(fetch_addr_o), 0);

        finish_run();
    end

endmodule